// File: doc/BRIEF.md
# CPU System Register File

This block keeps the processor's control and status state: the saved program counters and status words for maskable interrupts, non-maskable interrupts, table calls and debug traps, together with the interrupt cause, the live program status word and the table-call base pointer. Each of these is selected by a 5-bit register number. Software reaches them through two operations. A load (`wr_en`) copies a general-register value into the selected entry. A store (`rd_en`) reads the selected entry out.

The block checks every access against a fixed permission rule for each register number. The cause register can be read but not written. The debug save pair is reachable only while a debug trap is active. Unimplemented numbers allow no access at all. A refused access changes no state, reads as zero and raises `access_error` for one cycle. Three hardware save strobes model entry into an interrupt, an NMI or a debug trap. Each strobe captures a PC/PSW pair, and the interrupt and NMI strobes also capture the cause. Three return-address outputs present the saved PCs with bit 0 cleared, because instruction addresses are always even.

Top module: `sysreg_file`

## Requirements
- R1: After a synchronous reset, every implemented register reads as zero, except the PSW (number 5), which reads as the `PSW_RESET` parameter.
- R2: Numbers 0, 1, 2, 3, 5, 16, 17 and 20 accept a load and a store at any time, and a store returns the last value loaded, bit for bit.
- R3: Number 4 (cause) is store-only. A load to it changes nothing and is refused, and a store returns the cause value.
- R4: Numbers 6 to 15 and 21 to 31 are reserved. A load to one of them changes no register, and a store returns zero.
- R5: Numbers 18 and 19 (debug PC/PSW) are accessible only while `dbg_active` is 1. When it is 0, a load to them is ignored and a store returns zero.
- R6: `access_error` is 1 in the cycle after a clock edge that saw a refused load or store, and 0 after any edge with no refused access.
- R7: `irq_save` loads `save_pc` into number 0, `save_psw` into 1 and `save_cause` into 4. `nmi_save` loads numbers 2, 3 and 4 the same way. `dbg_save` loads numbers 18 and 19 and leaves 4 unchanged. At most one strobe is asserted in any cycle.
- R8: When a hardware save and a software load hit the same register in the same cycle, the hardware value is kept.
- R9: `irq_ret_pc`, `nmi_ret_pc` and `tbl_ret_pc` equal registers 0, 2 and 16, with bit 0 forced to 0.
- R10: Each save register has one copy only. A second save replaces the first save's value.
- R11: A load takes effect at the clock edge. A store is combinational from the current contents, and `rd_data` is zero whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_num | input | 5 | Selected register number |
| wr_en | input | 1 | Software load request |
| wr_data | input | XLEN | Value to load |
| rd_en | input | 1 | Software store request |
| rd_data | output | XLEN | Value read out (zero if refused or idle) |
| dbg_active | input | 1 | Debug trap in progress |
| irq_save | input | 1 | Hardware interrupt entry strobe |
| nmi_save | input | 1 | Hardware NMI entry strobe |
| dbg_save | input | 1 | Hardware debug-trap entry strobe |
| save_pc | input | XLEN | PC captured by a save strobe |
| save_psw | input | XLEN | PSW captured by a save strobe |
| save_cause | input | XLEN | Cause captured by interrupt/NMI strobes |
| psw | output | XLEN | Current program status word |
| irq_ret_pc | output | XLEN | Interrupt return address, bit 0 cleared |
| nmi_ret_pc | output | XLEN | NMI return address, bit 0 cleared |
| tbl_ret_pc | output | XLEN | Table-call return address, bit 0 cleared |
| access_error | output | 1 | One-cycle flag for a refused access |

## Verification
The assertions assume that at most one of the three save strobes is high in any cycle, because the block has no rule for ordering simultaneous entries. A check on the inputs enforces this. The stimulus raises one strobe at a time. It overlaps a software load with a save only to probe the hardware-over-software priority. Loads and stores are issued as single-cycle requests on quiet cycles, so each refusal flag can be tied to exactly one request.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int NUM_W   = 5;
  localparam int N_PAIRS = 4;

  localparam logic [NUM_W-1:0] RN_IRQ_PC   = 5'd0;
  localparam logic [NUM_W-1:0] RN_IRQ_PSW  = 5'd1;
  localparam logic [NUM_W-1:0] RN_NMI_PC   = 5'd2;
  localparam logic [NUM_W-1:0] RN_NMI_PSW  = 5'd3;
  localparam logic [NUM_W-1:0] RN_CAUSE    = 5'd4;
  localparam logic [NUM_W-1:0] RN_PSW      = 5'd5;
  localparam logic [NUM_W-1:0] RN_TBL_PC   = 5'd16;
  localparam logic [NUM_W-1:0] RN_TBL_PSW  = 5'd17;
  localparam logic [NUM_W-1:0] RN_DBG_PC   = 5'd18;
  localparam logic [NUM_W-1:0] RN_DBG_PSW  = 5'd19;
  localparam logic [NUM_W-1:0] RN_TBL_BASE = 5'd20;

  typedef enum logic [1:0] {PAIR_IRQ, PAIR_NMI, PAIR_TBL, PAIR_DBG} pair_e;

  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
  } perm_t;

  // Register number of the PC half of a save pair; the PSW half is the next number.
  function automatic logic [NUM_W-1:0] pair_pc_num(input int idx);
    case (idx)
      0:       return RN_IRQ_PC;
      1:       return RN_NMI_PC;
      2:       return RN_TBL_PC;
      default: return RN_DBG_PC;
    endcase
  endfunction
endpackage

// File: rtl/sysreg_perm.sv
module sysreg_perm
  import sysreg_pkg::*;
(
  input  logic [NUM_W-1:0] reg_num,
  input  logic             dbg_active,
  output perm_t            perm
);
  always_comb begin
    perm = '0;
    case (reg_num)
      RN_IRQ_PC, RN_IRQ_PSW, RN_NMI_PC, RN_NMI_PSW,
      RN_PSW, RN_TBL_PC, RN_TBL_PSW, RN_TBL_BASE: begin
        perm.rd_ok = 1'b1;
        perm.wr_ok = 1'b1;
      end
      RN_CAUSE: perm.rd_ok = 1'b1;
      RN_DBG_PC, RN_DBG_PSW: begin
        perm.rd_ok = dbg_active;
        perm.wr_ok = dbg_active;
      end
      default: perm = '0;
    endcase
  end
endmodule

// File: rtl/sysreg_save_pair.sv
module sysreg_save_pair #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hw_save,
  input  logic [XLEN-1:0] hw_pc,
  input  logic [XLEN-1:0] hw_psw,
  input  logic            sw_we_pc,
  input  logic            sw_we_psw,
  input  logic [XLEN-1:0] sw_data,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] psw_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      psw_q <= '0;
    end else if (hw_save) begin
      pc_q  <= hw_pc;
      psw_q <= hw_psw;
    end else begin
      if (sw_we_pc)  pc_q  <= sw_data;
      if (sw_we_psw) psw_q <= sw_data;
    end
  end
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
  import sysreg_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] PSW_RESET = 32'h0000_0020
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_W-1:0] reg_num,
  input  logic             wr_en,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             rd_en,
  output logic [XLEN-1:0]  rd_data,
  input  logic             dbg_active,
  input  logic             irq_save,
  input  logic             nmi_save,
  input  logic             dbg_save,
  input  logic [XLEN-1:0]  save_pc,
  input  logic [XLEN-1:0]  save_psw,
  input  logic [XLEN-1:0]  save_cause,
  output logic [XLEN-1:0]  psw,
  output logic [XLEN-1:0]  irq_ret_pc,
  output logic [XLEN-1:0]  nmi_ret_pc,
  output logic [XLEN-1:0]  tbl_ret_pc,
  output logic             access_error
);
  perm_t            perm;
  logic             wr_commit;
  logic [XLEN-1:0]  cause_q, psw_q, tbase_q;
  logic [XLEN-1:0]  pair_pc  [N_PAIRS];
  logic [XLEN-1:0]  pair_psw [N_PAIRS];
  logic [N_PAIRS-1:0] pair_hw;

  sysreg_perm u_perm (
    .reg_num    (reg_num),
    .dbg_active (dbg_active),
    .perm       (perm)
  );

  assign wr_commit = wr_en & perm.wr_ok;

  assign pair_hw[PAIR_IRQ] = irq_save;
  assign pair_hw[PAIR_NMI] = nmi_save;
  assign pair_hw[PAIR_TBL] = 1'b0;
  assign pair_hw[PAIR_DBG] = dbg_save;

  for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
    localparam logic [NUM_W-1:0] PC_NUM  = pair_pc_num(i);
    localparam logic [NUM_W-1:0] PSW_NUM = PC_NUM + 5'd1;
    sysreg_save_pair #(.XLEN(XLEN)) u_pair (
      .clk       (clk),
      .rst       (rst),
      .hw_save   (pair_hw[i]),
      .hw_pc     (save_pc),
      .hw_psw    (save_psw),
      .sw_we_pc  (wr_commit && reg_num == PC_NUM),
      .sw_we_psw (wr_commit && reg_num == PSW_NUM),
      .sw_data   (wr_data),
      .pc_q      (pair_pc[i]),
      .psw_q     (pair_psw[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q      <= '0;
      psw_q        <= PSW_RESET;
      tbase_q      <= '0;
      access_error <= 1'b0;
    end else begin
      if (irq_save || nmi_save)                 cause_q <= save_cause;
      if (wr_commit && reg_num == RN_PSW)       psw_q   <= wr_data;
      if (wr_commit && reg_num == RN_TBL_BASE)  tbase_q <= wr_data;
      access_error <= (wr_en && !perm.wr_ok) || (rd_en && !perm.rd_ok);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en && perm.rd_ok) begin
      case (reg_num)
        RN_IRQ_PC:   rd_data = pair_pc[PAIR_IRQ];
        RN_IRQ_PSW:  rd_data = pair_psw[PAIR_IRQ];
        RN_NMI_PC:   rd_data = pair_pc[PAIR_NMI];
        RN_NMI_PSW:  rd_data = pair_psw[PAIR_NMI];
        RN_CAUSE:    rd_data = cause_q;
        RN_PSW:      rd_data = psw_q;
        RN_TBL_PC:   rd_data = pair_pc[PAIR_TBL];
        RN_TBL_PSW:  rd_data = pair_psw[PAIR_TBL];
        RN_DBG_PC:   rd_data = pair_pc[PAIR_DBG];
        RN_DBG_PSW:  rd_data = pair_psw[PAIR_DBG];
        RN_TBL_BASE: rd_data = tbase_q;
        default:     rd_data = '0;
      endcase
    end
  end

  assign psw        = psw_q;
  assign irq_ret_pc = {pair_pc[PAIR_IRQ][XLEN-1:1], 1'b0};
  assign nmi_ret_pc = {pair_pc[PAIR_NMI][XLEN-1:1], 1'b0};
  assign tbl_ret_pc = {pair_pc[PAIR_TBL][XLEN-1:1], 1'b0};
endmodule

// File: rtl/sysreg_file_chk.sv
module sysreg_file_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [4:0]      reg_num,
  input logic            wr_en,
  input logic            rd_en,
  input logic            dbg_active,
  input logic            irq_save,
  input logic            nmi_save,
  input logic            dbg_save,
  input logic [XLEN-1:0] save_pc,
  input logic [XLEN-1:0] rd_data,
  input logic [XLEN-1:0] irq_ret_pc,
  input logic [XLEN-1:0] nmi_ret_pc,
  input logic [XLEN-1:0] cause,
  input logic            access_error
);
  logic reserved;
  assign reserved = (reg_num >= 5'd6 && reg_num <= 5'd15) || (reg_num >= 5'd21);

  assert_one_save_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_save, nmi_save, dbg_save}));

  assert_reserved_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reserved) |-> rd_data == '0);

  assert_debug_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !dbg_active && (reg_num == 5'd18 || reg_num == 5'd19)) |-> rd_data == '0);

  assert_reserved_flags_error_R6: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && reserved) |=> access_error);

  assert_idle_no_error_R6: assert property (@(posedge clk) disable iff (rst)
    !(rd_en || wr_en) |=> !access_error);

  assert_cause_readonly_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_num == 5'd4 && !irq_save && !nmi_save) |=> $stable(cause));

  assert_irq_save_wins_R8: assert property (@(posedge clk) disable iff (rst)
    irq_save |=> irq_ret_pc == {$past(save_pc[XLEN-1:1]), 1'b0});

  assert_nmi_ret_even_R9: assert property (@(posedge clk) disable iff (rst)
    nmi_save |=> nmi_ret_pc == {$past(save_pc[XLEN-1:1]), 1'b0});
endmodule

bind sysreg_file sysreg_file_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_num      (reg_num),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .dbg_active   (dbg_active),
  .irq_save     (irq_save),
  .nmi_save     (nmi_save),
  .dbg_save     (dbg_save),
  .save_pc      (save_pc),
  .rd_data      (rd_data),
  .irq_ret_pc   (irq_ret_pc),
  .nmi_ret_pc   (nmi_ret_pc),
  .cause        (cause_q),
  .access_error (access_error)
);

// File: tb/test_sysreg_file.sv
`timescale 1ns/1ps
module test_sysreg_file;
  localparam int XLEN = 32;
  localparam logic [31:0] PSW_RST = 32'h0000_0020;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] reg_num = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, dbg_active = 1'b0;
  logic irq_save = 1'b0, nmi_save = 1'b0, dbg_save = 1'b0;
  logic [31:0] wr_data = '0, save_pc = '0, save_psw = '0, save_cause = '0;
  logic [31:0] rd_data, psw, irq_ret_pc, nmi_ret_pc, tbl_ret_pc;
  logic access_error;

  always #4 clk = ~clk;

  sysreg_file #(.XLEN(XLEN), .PSW_RESET(PSW_RST)) i_sysreg_file (
    .clk(clk), .rst(rst), .reg_num(reg_num), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .dbg_active(dbg_active),
    .irq_save(irq_save), .nmi_save(nmi_save), .dbg_save(dbg_save),
    .save_pc(save_pc), .save_psw(save_psw), .save_cause(save_cause),
    .psw(psw), .irq_ret_pc(irq_ret_pc), .nmi_ret_pc(nmi_ret_pc),
    .tbl_ret_pc(tbl_ret_pc), .access_error(access_error)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] mdl [32];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit rd_ok(input int n, input bit d);
    return (n <= 5) || n == 16 || n == 17 || n == 20 || ((n == 18 || n == 19) && d);
  endfunction

  function automatic bit wr_ok(input int n, input bit d);
    return rd_ok(n, d) && n != 4;
  endfunction

  // Monitor: pops one expected item per store cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (rd_en) begin
        if (sb_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R11: unexpected read, actual %h expected none", rd_data);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check(it.tag, rd_data, it.exp);
        end
      end
    end
  end

  task automatic sw_write(input int n, input logic [31:0] v, input bit d, input string tag);
    bit ok;
    ok = wr_ok(n, d);
    @(posedge clk); #1;
    reg_num = n[4:0]; wr_data = v; wr_en = 1'b1; dbg_active = d;
    @(posedge clk); #1;
    wr_en = 1'b0; dbg_active = 1'b0;
    if (ok) mdl[n] = v;
    @(negedge clk);
    check({tag, " R6 error flag after load"}, {31'd0, access_error}, {31'd0, !ok});
  endtask

  task automatic sw_read(input int n, input bit d, input string tag);
    item_t it;
    bit ok;
    ok = rd_ok(n, d);
    it.exp = ok ? mdl[n] : 32'd0;
    it.tag = tag;
    @(posedge clk); #1;
    reg_num = n[4:0]; rd_en = 1'b1; dbg_active = d;
    sb_q.push_back(it);
    @(posedge clk); #1;
    rd_en = 1'b0; dbg_active = 1'b0;
    @(negedge clk);
    check({tag, " R6 error flag after store"}, {31'd0, access_error}, {31'd0, !ok});
  endtask

  // kind 0 = interrupt, 1 = NMI, 2 = debug
  task automatic hw_save(input int kind, input logic [31:0] pc, input logic [31:0] ps,
                         input logic [31:0] cs, input bit with_sw, input int sn,
                         input logic [31:0] sv);
    @(posedge clk); #1;
    save_pc = pc; save_psw = ps; save_cause = cs;
    irq_save = (kind == 0); nmi_save = (kind == 1); dbg_save = (kind == 2);
    if (with_sw) begin
      reg_num = sn[4:0]; wr_data = sv; wr_en = 1'b1;
    end
    @(posedge clk); #1;
    irq_save = 1'b0; nmi_save = 1'b0; dbg_save = 1'b0; wr_en = 1'b0;
    if (with_sw && wr_ok(sn, 1'b0)) mdl[sn] = sv;
    case (kind)
      0: begin mdl[0] = pc; mdl[1] = ps; mdl[4] = cs; end
      1: begin mdl[2] = pc; mdl[3] = ps; mdl[4] = cs; end
      default: begin mdl[18] = pc; mdl[19] = ps; end
    endcase
  endtask

  task automatic check_ret(input string tag);
    @(negedge clk);
    check({tag, " R9 irq return"}, irq_ret_pc, {mdl[0][31:1], 1'b0});
    check({tag, " R9 nmi return"}, nmi_ret_pc, {mdl[2][31:1], 1'b0});
    check({tag, " R9 table return"}, tbl_ret_pc, {mdl[16][31:1], 1'b0});
    check({tag, " psw output"}, psw, mdl[5]);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    mdl[5] = PSW_RST;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state of every number (debug visible)
    for (int i = 0; i < 32; i++) sw_read(i, 1'b1, "R1 reset value");
    check_ret("R1");
    // R11: idle store port reads zero
    @(negedge clk);
    check("R11 idle rd_data", rd_data, 32'd0);

    // R2: full access registers, distinct patterns, odd PCs
    sw_write(0,  32'h8000_1235, 1'b0, "R2");
    sw_write(1,  32'h0000_00FF, 1'b0, "R2");
    sw_write(2,  32'hA5A5_A5A5, 1'b0, "R2");
    sw_write(3,  32'h5A5A_5A5A, 1'b0, "R2");
    sw_write(5,  32'h0000_0007, 1'b0, "R2");
    sw_write(16, 32'h0000_4001, 1'b0, "R2");
    sw_write(17, 32'hFFFF_FFFF, 1'b0, "R2");
    sw_write(20, 32'h1234_5678, 1'b0, "R2");
    foreach (mdl[i]) if (wr_ok(i, 1'b0)) sw_read(i, 1'b0, "R2 readback");
    // R9: return outputs clear bit 0, store keeps it
    check_ret("R9");

    // R3: cause is read-only
    sw_write(4, 32'hDEAD_BEEF, 1'b0, "R3");
    sw_read(4, 1'b0, "R3 cause unchanged");

    // R4: reserved numbers
    sw_write(7,  32'hCAFE_0001, 1'b1, "R4");
    sw_write(25, 32'hCAFE_0002, 1'b1, "R4");
    sw_write(31, 32'hCAFE_0003, 1'b1, "R4");
    for (int i = 0; i < 32; i++) sw_read(i, 1'b1, "R4 no register disturbed");
    sw_read(7, 1'b0, "R4 reserved store");

    // R5: debug pair gating
    sw_write(18, 32'h0000_0AAA, 1'b0, "R5 blocked");
    sw_read(18, 1'b1, "R5 blocked load ignored");
    sw_write(18, 32'h0000_0BBB, 1'b1, "R5 allowed");
    sw_write(19, 32'h0000_0CCC, 1'b1, "R5 allowed");
    sw_read(18, 1'b0, "R5 store refused");
    sw_read(19, 1'b0, "R5 store refused");
    sw_read(18, 1'b1, "R5 store allowed");
    sw_read(19, 1'b1, "R5 store allowed");

    // R7: hardware saves
    hw_save(0, 32'h0000_2001, 32'h0000_0011, 32'h0000_0080, 1'b0, 0, 32'd0);
    sw_read(0, 1'b0, "R7 irq pc");
    sw_read(1, 1'b0, "R7 irq psw");
    sw_read(4, 1'b0, "R7 irq cause");
    check_ret("R7");
    hw_save(1, 32'h0000_3003, 32'h0000_0022, 32'h0000_00C0, 1'b0, 0, 32'd0);
    sw_read(2, 1'b0, "R7 nmi pc");
    sw_read(3, 1'b0, "R7 nmi psw");
    sw_read(4, 1'b0, "R7 nmi cause");
    hw_save(2, 32'h0000_4444, 32'h0000_0033, 32'h0000_FFFF, 1'b0, 0, 32'd0);
    sw_read(18, 1'b1, "R7 debug pc");
    sw_read(19, 1'b1, "R7 debug psw");
    sw_read(4, 1'b0, "R7 debug leaves cause");

    // R10: second save overwrites
    hw_save(0, 32'h0000_5556, 32'h0000_0044, 32'h0000_0090, 1'b0, 0, 32'd0);
    sw_read(0, 1'b0, "R10 overwrite pc");
    sw_read(1, 1'b0, "R10 overwrite psw");

    // R8: hardware wins over same-cycle load, other register still loads
    hw_save(0, 32'h0000_6001, 32'h0000_0055, 32'h0000_00A0, 1'b1, 0, 32'h0BAD_0000);
    sw_read(0, 1'b0, "R8 hardware wins pc");
    hw_save(1, 32'h0000_7000, 32'h0000_0066, 32'h0000_00B0, 1'b1, 3, 32'h0BAD_0001);
    sw_read(3, 1'b0, "R8 hardware wins psw");
    hw_save(0, 32'h0000_8000, 32'h0000_0077, 32'h0000_00D0, 1'b1, 20, 32'h0000_9999);
    sw_read(20, 1'b0, "R8 unrelated load kept");
    sw_read(4, 1'b0, "R8 cause");
    check_ret("R8");

    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R6 quiet after idle", {31'd0, access_error}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule